// File: doc/BRIEF.md
# 8-bit ALU with Nibble-Carry Flags

An arithmetic and logic unit for a small accumulator-style processor. The 8-bit result is combinational and follows the operands and operation select at once. The flag byte is registered inside the block and loaded at the clock edge of a cycle that carries the operation strobe. The registered flag byte also supplies the incoming carry to the operations that consume it. The block also has a 16-bit add/subtract path with its own half-carry rule.

Each flag is a single bit in the flag byte: Zero at bit 7, Subtract at bit 6, HalfCarry at bit 5 and Carry at bit 4. Bits 3..0 always read as zero. Instruction decode, register storage, memory and the program counter belong to the surrounding processor.

Top module: `nib_alu`

## Requirements
- R1: Reset (rst_n low) clears the flag byte to 0x00. Bits 3..0 of the flag byte are always zero. The flag layout is Zero bit 7, Subtract bit 6, HalfCarry bit 5, Carry bit 4.
- R2: The flag byte loads only at a rising clock edge with op_valid high. Otherwise it holds its value. result and wide_result are combinational.
- R3: ADD (op_sel 0) and ADC (op_sel 1) give opa+opb (+Carry for ADC) modulo 256. They clear Subtract, set Carry on carry out of bit 7, set Zero on a zero result and set HalfCarry when the low-nibble sum reaches 0x10.
- R4: SUB (op_sel 2) and SBC (op_sel 3) give opa-opb (-Carry for SBC) modulo 256. They set Subtract, set Carry on a borrow, set Zero on a zero result and set HalfCarry on a low-nibble borrow.
- R5: The ADC/SBC carry-in is a third term in the full and nibble carry chains, so opb=0xFF with carry-in 1 still reports Carry and HalfCarry.
- R6: INC (op_sel 4) and DEC (op_sel 5) give opa+1 and opa-1, wrapped, and update Zero and HalfCarry. INC clears Subtract and DEC sets it. Carry is unchanged by both.
- R7: RLC (op_sel 6) and RRC (op_sel 7) rotate opa left or right by one bit. The bit shifted out goes into the vacated bit and into Carry.
- R8: RL (op_sel 8) and RR (op_sel 9) rotate through carry. The old Carry enters the vacated bit and the bit shifted out becomes the new Carry.
- R9: SLA (op_sel 10) shifts left and SRL (op_sel 11) shifts right, filling with 0. For R7 to R9, Carry equals the bit shifted out, Subtract and HalfCarry are cleared, and Zero reflects the result.
- R10: BIT (op_sel 12) sets Zero when bit opb[2:0] of opa is 0 and clears it otherwise. Subtract, HalfCarry and Carry are unchanged, and result equals opa.
- R11: ADD16 (op_sel 13) and SUB16 (op_sel 14) output wide_a±wide_b on wide_result. HalfCarry is the carry or borrow out of the low 12 bits. Carry and Zero come from the 16-bit operation, and Subtract is clear for add and set for subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag byte |
| op_valid | input | 1 | Operation strobe; loads the flag byte |
| op_sel | input | 4 | Operation select |
| opa | input | 8 | First 8-bit operand |
| opb | input | 8 | Second 8-bit operand; bit index for BIT |
| wide_a | input | 16 | First 16-bit operand |
| wide_b | input | 16 | Second 16-bit operand |
| result | output | 8 | 8-bit result |
| wide_result | output | 16 | 16-bit result |
| flags | output | 8 | Registered flag byte |

## Verification
The assertions assume that op_valid is low while reset is held and that op_sel is always a known value when the strobe is high. The stimulus meets this by holding op_valid at zero through every reset. It drives op_sel, the operands and the strobe only on falling clock edges. Before each table vector, a preparatory ADD puts Carry into a known state, so the carry-dependent cases start from a defined flag byte.

// File: rtl/nib_alu.sv
module nib_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_sel,
  input  logic [7:0]  opa,
  input  logic [7:0]  opb,
  input  logic [15:0] wide_a,
  input  logic [15:0] wide_b,
  output logic [7:0]  result,
  output logic [15:0] wide_result,
  output logic [7:0]  flags
);
  localparam int ZB = 7;
  localparam int NB = 6;
  localparam int HB = 5;
  localparam int CB = 4;

  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_INC = 4'd4, OP_DEC = 4'd5, OP_RLC = 4'd6, OP_RRC = 4'd7,
                         OP_RL  = 4'd8, OP_RR  = 4'd9, OP_SLA = 4'd10, OP_SRL = 4'd11,
                         OP_BIT = 4'd12, OP_ADD16 = 4'd13, OP_SUB16 = 4'd14;

  logic        cin;
  logic [7:0]  b_eff;
  logic [8:0]  sum9, dif9;
  logic [4:0]  sumh, difh;
  logic [16:0] wsum, wdif;
  logic [12:0] wsumh, wdifh;
  logic [7:0]  nxt;
  logic        sh_out;

  assign cin   = ((op_sel == OP_ADC) || (op_sel == OP_SBC)) && flags[CB];
  assign b_eff = ((op_sel == OP_INC) || (op_sel == OP_DEC)) ? 8'h01 : opb;

  assign sum9  = {1'b0, opa} + {1'b0, b_eff} + {8'h00, cin};
  assign dif9  = {1'b0, opa} - {1'b0, b_eff} - {8'h00, cin};
  assign sumh  = {1'b0, opa[3:0]} + {1'b0, b_eff[3:0]} + {4'h0, cin};
  assign difh  = {1'b0, opa[3:0]} - {1'b0, b_eff[3:0]} - {4'h0, cin};

  assign wsum  = {1'b0, wide_a} + {1'b0, wide_b};
  assign wdif  = {1'b0, wide_a} - {1'b0, wide_b};
  assign wsumh = {1'b0, wide_a[11:0]} + {1'b0, wide_b[11:0]};
  assign wdifh = {1'b0, wide_a[11:0]} - {1'b0, wide_b[11:0]};

  assign wide_result = (op_sel == OP_SUB16) ? wdif[15:0] : wsum[15:0];

  always_comb begin
    result = opa;
    nxt    = flags;
    sh_out = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        result = sum9[7:0];
        nxt = {~|sum9[7:0], 1'b0, sumh[4], sum9[8], 4'h0};
      end
      OP_SUB, OP_SBC: begin
        result = dif9[7:0];
        nxt = {~|dif9[7:0], 1'b1, difh[4], dif9[8], 4'h0};
      end
      OP_INC: begin
        result = sum9[7:0];
        nxt = {~|sum9[7:0], 1'b0, sumh[4], flags[CB], 4'h0};
      end
      OP_DEC: begin
        result = dif9[7:0];
        nxt = {~|dif9[7:0], 1'b1, difh[4], flags[CB], 4'h0};
      end
      OP_RLC, OP_RL, OP_SLA: begin
        sh_out = opa[7];
        case (op_sel)
          OP_RLC:  result = {opa[6:0], opa[7]};
          OP_RL:   result = {opa[6:0], flags[CB]};
          default: result = {opa[6:0], 1'b0};
        endcase
        nxt = {~|result, 2'b00, sh_out, 4'h0};
      end
      OP_RRC, OP_RR, OP_SRL: begin
        sh_out = opa[0];
        case (op_sel)
          OP_RRC:  result = {opa[0], opa[7:1]};
          OP_RR:   result = {flags[CB], opa[7:1]};
          default: result = {1'b0, opa[7:1]};
        endcase
        nxt = {~|result, 2'b00, sh_out, 4'h0};
      end
      OP_BIT: begin
        nxt[ZB] = ~opa[opb[2:0]];
      end
      OP_ADD16: begin
        nxt = {~|wsum[15:0], 1'b0, wsumh[12], wsum[16], 4'h0};
      end
      OP_SUB16: begin
        nxt = {~|wdif[15:0], 1'b1, wdifh[12], wdif[16], 4'h0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flags <= 8'h00;
    else if (op_valid) flags <= nxt;
  end

  assert_low_nibble_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3:0] == 4'h0);

  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags));

  assert_add_clears_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel == OP_ADD || op_sel == OP_ADC) |=> !flags[NB]);

  assert_sub_sets_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel == OP_SUB || op_sel == OP_SBC) |=> flags[NB]);

  assert_incdec_keep_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel == OP_INC || op_sel == OP_DEC) |=> flags[CB] == $past(flags[CB]));

  assert_circ_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_sel == OP_RLC |=> flags[CB] == $past(result[0]));

  assert_through_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_sel == OP_RL |=> $past(result[0]) == $past(flags[CB]));

  assert_shift_clears_nh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel >= OP_RLC && op_sel <= OP_SRL) |=> !flags[NB] && !flags[HB]);

  assert_bit_keeps_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_sel == OP_BIT |=> flags[6:4] == $past(flags[6:4]));

  assert_wide_sub_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_sel == OP_SUB16 |=> flags[NB]);
endmodule

// File: tb/nib_alu_test.sv
module nib_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [7:0]  opa = 8'h00, opb = 8'h00;
  logic [15:0] wide_a = 16'h0, wide_b = 16'h0;
  logic [7:0]  result;
  logic [15:0] wide_result;
  logic [7:0]  flags;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nib_alu uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
               .opa(opa), .opb(opb), .wide_a(wide_a), .wide_b(wide_b),
               .result(result), .wide_result(wide_result), .flags(flags));

  // {op, carry-in, a, b, expected result, expected flags}
  localparam int NV = 23;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  1'b0, 8'h0F, 8'h01, 8'h10, 8'h20},
    {4'd0,  1'b0, 8'h80, 8'h80, 8'h00, 8'h90},
    {4'd0,  1'b0, 8'h3A, 8'hC6, 8'h00, 8'hB0},
    {4'd1,  1'b1, 8'h00, 8'hFF, 8'h00, 8'hB0},
    {4'd1,  1'b1, 8'h12, 8'h34, 8'h47, 8'h00},
    {4'd2,  1'b0, 8'h10, 8'h01, 8'h0F, 8'h60},
    {4'd2,  1'b0, 8'h05, 8'h05, 8'h00, 8'hC0},
    {4'd2,  1'b0, 8'h01, 8'h02, 8'hFF, 8'h70},
    {4'd3,  1'b1, 8'h10, 8'h0F, 8'h00, 8'hE0},
    {4'd3,  1'b1, 8'h00, 8'hFF, 8'h00, 8'hF0},
    {4'd4,  1'b1, 8'hFF, 8'h00, 8'h00, 8'hB0},
    {4'd4,  1'b0, 8'h0E, 8'h00, 8'h0F, 8'h00},
    {4'd5,  1'b1, 8'h10, 8'h00, 8'h0F, 8'h70},
    {4'd5,  1'b0, 8'h01, 8'h00, 8'h00, 8'hC0},
    {4'd6,  1'b0, 8'h85, 8'h00, 8'h0B, 8'h10},
    {4'd7,  1'b0, 8'h01, 8'h00, 8'h80, 8'h10},
    {4'd8,  1'b1, 8'h80, 8'h00, 8'h01, 8'h10},
    {4'd8,  1'b0, 8'h80, 8'h00, 8'h00, 8'h90},
    {4'd9,  1'b1, 8'h02, 8'h00, 8'h81, 8'h00},
    {4'd10, 1'b1, 8'h40, 8'h00, 8'h80, 8'h00},
    {4'd11, 1'b0, 8'h01, 8'h00, 8'h00, 8'h90},
    {4'd12, 1'b1, 8'h08, 8'h03, 8'h08, 8'h30},
    {4'd12, 1'b0, 8'hF7, 8'h03, 8'hF7, 8'h80}
  };

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R3";
      4'd2, 4'd3:        return "R4";
      4'd4, 4'd5:        return "R6";
      4'd6, 4'd7:        return "R7";
      4'd8, 4'd9:        return "R8";
      4'd10, 4'd11:      return "R9";
      4'd12:             return "R10";
      default:           return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [7:0]  got_res;
  logic [15:0] got_wide;

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] wa, input logic [15:0] wb, input bit strobe);
    @(negedge clk);
    op_sel = op; opa = a; opb = b; wide_a = wa; wide_b = wb; op_valid = strobe;
    #2;
    got_res = result;
    got_wide = wide_result;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic set_carry(input bit c);
    run_op(4'd0, c ? 8'hFF : 8'h00, 8'h01, 16'h0, 16'h0, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1", "reset flags", {8'h0, flags}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      set_carry(VEC[i][32]);
      run_op(VEC[i][36:33], VEC[i][31:24], VEC[i][23:16], 16'h0, 16'h0, 1'b1);
      check(tag(VEC[i][36:33]), $sformatf("vec %0d result", i), {8'h0, got_res}, {8'h0, VEC[i][15:8]});
      check(tag(VEC[i][36:33]), $sformatf("vec %0d flags", i), {8'h0, flags}, {8'h0, VEC[i][7:0]});
    end

    // R5: carry-in 1 with operand 0xFF must still report both carries
    set_carry(1'b1);
    run_op(4'd1, 8'h01, 8'hFF, 16'h0, 16'h0, 1'b1);
    check("R5", "adc 01+FF+1 result", {8'h0, got_res}, 16'h0001);
    check("R5", "adc 01+FF+1 flags", {8'h0, flags}, 16'h0030);

    // R11: 16-bit path
    run_op(4'd13, 8'h00, 8'h00, 16'h0FFF, 16'h0001, 1'b1);
    check("R11", "add16 result", got_wide, 16'h1000);
    check("R11", "add16 flags", {8'h0, flags}, 16'h0020);
    run_op(4'd13, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 1'b1);
    check("R11", "add16 wrap result", got_wide, 16'h0000);
    check("R11", "add16 wrap flags", {8'h0, flags}, 16'h00B0);
    run_op(4'd14, 8'h00, 8'h00, 16'h1000, 16'h0001, 1'b1);
    check("R11", "sub16 result", got_wide, 16'h0FFF);
    check("R11", "sub16 flags", {8'h0, flags}, 16'h0060);
    run_op(4'd14, 8'h00, 8'h00, 16'h0000, 16'h0001, 1'b1);
    check("R11", "sub16 borrow result", got_wide, 16'hFFFF);
    check("R11", "sub16 borrow flags", {8'h0, flags}, 16'h0070);

    // R2: no strobe, flags hold while result still follows inputs
    set_carry(1'b0);
    run_op(4'd0, 8'h80, 8'h80, 16'h0, 16'h0, 1'b0);
    check("R2", "unstrobed result", {8'h0, got_res}, 16'h0000);
    check("R2", "unstrobed flags hold", {8'h0, flags}, 16'h0000);

    // R1: reset in mid-run clears flags
    set_carry(1'b1);
    check("R1", "flags before reset", {8'h0, flags}, 16'h00B0);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk) #1;
    check("R1", "flags after reset", {8'h0, flags}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule